// File: doc/BRIEF.md
# Capture Memory Readout Index

This block gives a host register-level read access to three capture memories that are filled side by side. Each memory holds 1024 words of 16 bits. One shared 10-bit index selects the entry shown in every channel's output register. All three channels therefore move together, and the host can walk a whole capture by reading one channel register after another.

The host moves the index by writing it one byte per register write, or by letting it advance by itself. A read of any channel output register bumps the index by one. The three output registers then reload from the new entry on the following cycle. When the capture side signals that a capture has finished, the index returns to zero and entry zero of each memory is presented. Reads return data combinationally on `reg_rdata` in the cycle the strobe is high.

Top module: `cap_readout_top`

## Requirements
- R1: After reset the index is 0, each of the three channel output registers holds 0x0000, and a read of an unmapped address returns 0x0000.
- R2: A one-cycle pulse on `cap_done` forces the index to 0, and one cycle later the three output registers hold entry 0 of their memories.
- R3: A register write to address 0x10 puts `reg_wdata` into index bits [7:0] at that clock edge. A write to address 0x11 puts `reg_wdata[1:0]` into index bits [9:8], and `reg_wdata[7:2]` are ignored.
- R4: A read of address 0x10 returns the index in bits [9:0], with bits [15:10] zero.
- R5: A read strobe on a channel address (0x12 for channel 0, 0x14 for channel 1, 0x16 for channel 2) returns that channel's output register and increments the index by one.
- R6: Incrementing the index from 1023 wraps it to 0.
- R7: A read of the index address, or of any address that is not a channel address, leaves the index unchanged.
- R8: The output registers reload from the memories one cycle after every index change, and only then. A memory write at the current index is not visible until the next index change.
- R9: When `cap_done` and a host index write arrive in the same cycle, `cap_done` wins and the index becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_we | input | 1 | Capture-side write enable for all three memories |
| cap_waddr | input | 10 | Capture-side write entry |
| cap_wdata | input | 48 | Capture-side data, channel 0 in bits [15:0], channel 1 in [31:16], channel 2 in [47:32] |
| cap_done | input | 1 | One-cycle pulse marking the end of a capture |
| reg_wr | input | 1 | Host byte-write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 7 | Host register address |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 16 | Host read data, valid in the strobe cycle |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that `cap_done` is a pulse and that the host leaves at least one idle cycle after each strobe, so a channel read never sees an output register still waiting for its reload. The stimulus drives every strobe for exactly one cycle and follows it with an idle cycle. It raises `cap_done` together with a host write only in the case built to test priority.

// File: rtl/cap_readout_pkg.sv
// Shared sizes and register addresses for the capture readout block.
// Assumes the index is at least 9 and at most 16 bits wide.
package cap_readout_pkg;
    localparam int IDX_W   = 10;
    localparam int DATA_W  = 16;
    localparam int N_CH    = 3;
    localparam int ADDR_W  = 7;
    localparam logic [ADDR_W-1:0] A_IDX_LO  = 7'h10;
    localparam logic [ADDR_W-1:0] A_IDX_HI  = 7'h11;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 7'h12;
    localparam int   CH_STRIDE = 2;
endpackage

// File: rtl/cap_index_ptr.sv
// Shared readout index. Priority order: capture done, host byte write,
// auto-increment. Raises 'changed' for one cycle after any update.
// Assumes wr_lo, wr_hi and inc are never high together.
module cap_index_ptr #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_done,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             changed
);
    localparam int HI_W = IDX_W - 8;

    logic [IDX_W-1:0] idx_q;
    logic             chg_q;

    // Index update with done > write > increment priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            chg_q <= 1'b0;
        end else begin
            chg_q <= cap_done | wr_lo | wr_hi | inc;
            if (cap_done)
                idx_q <= '0;
            else if (wr_lo)
                idx_q[7:0] <= wdata;
            else if (wr_hi)
                idx_q[IDX_W-1:8] <= wdata[HI_W-1:0];
            else if (inc)
                idx_q <= idx_q + 1'b1;
        end
    end

    assign idx     = idx_q;
    assign changed = chg_q;

    a_r2_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> (idx_q == '0));
    a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !cap_done) |=> (idx_q[7:0] == $past(wdata)));
    a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cap_done && !wr_lo && !wr_hi && idx_q != '1)
        |=> (idx_q == $past(idx_q) + 1'b1));
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cap_done && !wr_lo && !wr_hi && idx_q == '1) |=> (idx_q == '0));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_done && !wr_lo && !wr_hi && !inc) |=> $stable(idx_q));
endmodule

// File: rtl/cap_chan_store.sv
// One channel: capture memory with a write port for the capture side
// and an output register reloaded from the current index on 'load'.
// Assumes raddr is stable in the cycle 'load' is high.
module cap_chan_store #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] out_q;

    // Capture-side fill of the memory.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Output register reload from the indexed entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (load)
            out_q <= mem[raddr];
    end

    assign dout = out_q;

    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(out_q));
endmodule

// File: rtl/cap_reg_decode.sv
// Host register decode: byte strobes for the index, increment on any
// channel read, and the read-data mux. Unmapped reads return zero.
// Assumes reg_wr and reg_rd are not high in the same cycle.
module cap_reg_decode
    import cap_readout_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16,
    parameter int NCH    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [IDX_W-1:0]           idx,
    input  logic [NCH-1:0][DATA_W-1:0] ch_dout,
    output logic                       wr_lo,
    output logic                       wr_hi,
    output logic                       inc,
    output logic [DATA_W-1:0]          rdata
);
    logic [NCH-1:0] ch_hit;

    // Channel address match, one bit per channel.
    for (genvar k = 0; k < NCH; k++) begin : g_hit
        assign ch_hit[k] = (reg_addr == A_CH_BASE + ADDR_W'(k * CH_STRIDE));
    end

    assign wr_lo = reg_wr && (reg_addr == A_IDX_LO);
    assign wr_hi = reg_wr && (reg_addr == A_IDX_HI);
    assign inc   = reg_rd && (|ch_hit);

    // Read-data selection.
    always_comb begin
        rdata = '0;
        if (reg_addr == A_IDX_LO)
            rdata = DATA_W'(idx);
        for (int k = 0; k < NCH; k++)
            if (ch_hit[k])
                rdata = ch_dout[k];
    end

    a_r4_idx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_IDX_LO) |-> (rdata[DATA_W-1:IDX_W] == '0));
    a_r7_no_inc_on_idx_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !(|ch_hit)) |-> !inc);
    a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
endmodule

// File: rtl/cap_readout_top.sv
// Top of the capture readout block: shared index, host decode and
// three channel stores built by a generate loop.
// Assumes one idle cycle after each host strobe before the next read.
module cap_readout_top
    import cap_readout_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_we,
    input  logic [IDX_W-1:0]       cap_waddr,
    input  logic [N_CH*DATA_W-1:0] cap_wdata,
    input  logic                   cap_done,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [7:0]             reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata
);
    logic [IDX_W-1:0]             idx;
    logic                         changed;
    logic                         wr_lo, wr_hi, inc;
    logic [N_CH-1:0][DATA_W-1:0]  ch_dout;

    cap_index_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .cap_done(cap_done),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata), .inc(inc),
        .idx(idx), .changed(changed)
    );

    cap_reg_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NCH(N_CH)) u_dec (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .idx(idx), .ch_dout(ch_dout),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .inc(inc), .rdata(reg_rdata)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        cap_chan_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
            .clk(clk), .rst_n(rst_n), .we(cap_we), .waddr(cap_waddr),
            .wdata(cap_wdata[c*DATA_W +: DATA_W]),
            .load(changed), .raddr(idx), .dout(ch_dout[c])
        );
    end

    a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && reg_wr) |=> (idx == '0));
    a_r2_reload_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> changed);
endmodule

// File: tb/sim_cap_readout_top.sv
module sim_cap_readout_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_we = 1'b0;
    logic [9:0]  cap_waddr = '0;
    logic [47:0] cap_wdata = '0;
    logic        cap_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    cap_readout_top u0 (
        .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .cap_waddr(cap_waddr),
        .cap_wdata(cap_wdata), .cap_done(cap_done), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    localparam logic [6:0] AIL = 7'h10, AIH = 7'h11;
    localparam logic [6:0] AC0 = 7'h12, AC1 = 7'h14, AC2 = 7'h16;
    localparam int NV = 5;
    localparam logic [15:0] VEC [NV] = '{16'h0138, 16'hFC05, 16'h03FF, 16'h0200, 16'h0080};
    localparam logic [9:0]  VIDX [NV] = '{10'd312, 10'd5, 10'd1023, 10'd512, 10'd128};

    function automatic logic [15:0] pat(input int ch, input int i);
        return 16'((ch + 1) << 12) ^ 16'(i * 7) ^ 16'h00A5;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [6:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [6:0] a, output logic [15:0] q);
        reg_addr = a; reg_rd = 1'b1;
        #1 q = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        cap_done = 1'b1;
        @(negedge clk);
        cap_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        do_rd(AIL, q);        chk("R1 index after reset", q, 16'h0000);
        do_rd(7'h30, q);      chk("R1 unmapped read", q, 16'h0000);
        do_rd(AC0, q);        chk("R1 ch0 output after reset", q, 16'h0000);

        // fill memories
        for (int i = 0; i < 1024; i++) begin
            cap_we = 1'b1; cap_waddr = 10'(i);
            cap_wdata = {pat(2, i), pat(1, i), pat(0, i)};
            @(negedge clk);
        end
        cap_we = 1'b0;
        @(negedge clk);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            int b;
            b = int'(VIDX[v]);
            do_wr(AIL, VEC[v][7:0]);
            do_wr(AIH, VEC[v][15:8]);
            do_rd(AIL, q);  chk("R3 R4 index after byte writes", q, {6'b0, VIDX[v]});
            do_rd(AC0, q);  chk("R5 ch0 read", q, pat(0, b));
            do_rd(AC1, q);  chk("R5 R6 ch1 read after increment", q, pat(1, (b + 1) % 1024));
            do_rd(AC2, q);  chk("R5 R6 ch2 read after increment", q, pat(2, (b + 2) % 1024));
        end
        do_rd(AIL, q);      chk("R6 index after walk", q, 16'd131);

        // R3 low byte alone takes effect immediately
        do_wr(AIL, 8'h07);
        do_rd(AIL, q);      chk("R3 low byte only", q, 16'd7);

        // R2 capture done
        do_wr(AIH, 8'h02);
        pulse_done();
        do_rd(AIL, q);      chk("R2 index zero after done", q, 16'h0000);
        do_rd(AC1, q);      chk("R2 ch1 entry zero after done", q, pat(1, 0));

        // R9 done beats host write
        cap_done = 1'b1; reg_addr = AIL; reg_wdata = 8'h55; reg_wr = 1'b1;
        @(negedge clk);
        cap_done = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        do_rd(AIL, q);      chk("R9 done wins over write", q, 16'h0000);

        // R7 reads of index and unmapped addresses do not move it
        do_wr(AIL, 8'h2C);
        do_rd(AIL, q);
        do_rd(7'h13, q);
        do_rd(7'h40, q);
        do_rd(AIL, q);      chk("R7 index unchanged by non-channel reads", q, 16'h002C);
        do_rd(AC2, q);      chk("R7 ch2 still shows entry", q, pat(2, 44));

        // R8 memory write at current index hidden until index change
        pulse_done();
        cap_we = 1'b1; cap_waddr = 10'd0;
        cap_wdata = {16'hC002, 16'hC001, 16'hC000};
        @(negedge clk);
        cap_we = 1'b0;
        @(negedge clk);
        do_rd(AC1, q);      chk("R8 stale until index change", q, pat(1, 0));
        do_wr(AIL, 8'h00);
        do_rd(AC2, q);      chk("R8 reloaded after index change", q, 16'hC002);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule